// File: doc/BRIEF.md
# 1-Wire Bus Bit Monitor

A passive observer for a single open-drain 1-Wire line. It never drives the bus. It times every low pulse on the line against a programmable time unit, given as a count of system clock cycles. From that timing it turns the line activity into three kinds of event: a received data byte, a bus reset, and a pulse it cannot classify.

Every bus cycle opens on a falling edge and closes on the next rising edge. The line's level exactly one time unit after the falling edge is taken as the bit value of that slot. The length of the low pulse sorts the cycle:

- A short pulse is a data slot.
- A pulse of eight or more units is a bus reset.
- Anything in between is an error.

Bits are collected least significant first, and every eighth data slot yields a byte strobe. An overdrive select divides the configured time unit by a power of two, so the same unit setting serves the faster bus speed.

The line input passes through a clock-domain synchroniser inside the block. After reset, edge detection stays blind until the synchroniser holds a real sample of the line.

Top module: `owm_bit_monitor`

## Requirements
- R1: After reset `byte_vld_o`, `bus_rst_o` and `err_o` are 0 and `byte_o` is 0x00.
- R2: A falling edge of the line opens a slot. The slot's bit is the synchronised line level exactly U cycles after the falling edge, where U is the effective time unit. A low pulse of N cycles with N <= U yields bit 1, and U < N < 2U yields bit 0. N equal to U, where the sample falls in the rising-edge cycle, gives 1.
- R3: A low pulse of N < 2U cycles is a data slot. The slot resolves at the rising edge, or at the sample point if that comes later.
- R4: Data bits are assembled LSB-first: the first slot is bit 0 of `byte_o`. After the eighth data slot `byte_vld_o` is high for exactly one cycle, with the byte on `byte_o`. The bit count then restarts at zero.
- R5: A low pulse of N >= 8U cycles gives a one-cycle `bus_rst_o` strobe. It also discards any partially collected bits.
- R6: A low pulse with 2U <= N < 8U gives a one-cycle `err_o` strobe. It also discards any partially collected bits.
- R7: With `od_mode_i` = 0, U = `unit_i`. With `od_mode_i` = 1, U = `unit_i` >> OD_SHIFT (default 2). In both cases U is forced to at least 1.
- R8: No edge is recognised before the synchroniser holds a valid sample of the line. A line that is low out of reset and later rises produces no event. A rising edge without a preceding falling edge produces no event.
- R9: At most one of `byte_vld_o`, `bus_rst_o`, `err_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Bus line level (1 = released/high) |
| unit_i | input | UNIT_W (12) | Time unit in clock cycles |
| od_mode_i | input | 1 | Overdrive select: shorter time unit |
| byte_vld_o | output | 1 | One-cycle strobe: a byte was completed |
| byte_o | output | DATA_W (8) | Last completed byte, LSB received first |
| bus_rst_o | output | 1 | One-cycle strobe: reset pulse seen |
| err_o | output | 1 | One-cycle strobe: unclassifiable low pulse |

## Verification
The delicate coincidence is the sample point landing in the same cycle as the rising edge. This happens when the low pulse lasts exactly U cycles. The bench provokes it in a byte whose slot lengths sit on the boundaries (U, U+1 and 2U-1 cycles), so any off-by-one in the sample point or the data/error window corrupts the byte. A scoreboard compares the corrupted byte against the byte computed from the rules. The second overlap is a classification event arriving while a byte is half collected. Reset and error pulses are inserted after three or five bits, and the byte that follows must come out clean, with nothing emitted for the abandoned bits.

// File: rtl/owm_pkg.sv
package owm_pkg;

   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_BIT  = 2'd1,
      EV_RST  = 2'd2,
      EV_ERR  = 2'd3
   } owm_ev_e;

   localparam int unsigned OWM_RST_MULT  = 8;
   localparam int unsigned OWM_DATA_MULT = 2;

endpackage

// File: rtl/owm_line_sync.sv
module owm_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o,
   output logic fall_o,
   output logic rise_o
);

   logic [STAGES-1:0] vld_pipe;
   logic              line_s;
   logic              prev_q;
   logic              seen_q;

   generate
      if (STAGES == 1) begin : g_one
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b1;
            else        s_q <= line_i;
         end
         assign line_s = s_q;
      end else begin : g_chain
         logic [STAGES-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '1;
            else        s_q <= {s_q[STAGES-2:0], line_i};
         end
         assign line_s = s_q[STAGES-1];
      end
   endgenerate

   generate
      if (STAGES == 1) begin : g_vld_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vld_pipe <= '0;
            else        vld_pipe <= 1'b1;
         end
      end else begin : g_vld_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vld_pipe <= '0;
            else        vld_pipe <= {vld_pipe[STAGES-2:0], 1'b1};
         end
      end
   endgenerate

   // first valid sample only loads the previous-value register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         seen_q <= 1'b0;
      end else if (vld_pipe[STAGES-1]) begin
         prev_q <= line_s;
         seen_q <= 1'b1;
      end
   end

   assign line_o = line_s;
   assign fall_o = seen_q &  prev_q & ~line_s;
   assign rise_o = seen_q & ~prev_q &  line_s;

   a_r8_fall_from_high: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |-> ($past(line_o) && !line_o));

   a_r8_rise_from_low: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |-> (!$past(line_o) && line_o));

endmodule

// File: rtl/owm_slot_timer.sv
module owm_slot_timer
   import owm_pkg::*;
#(
   parameter int unsigned UNIT_W = 12,
   localparam int unsigned CNT_W = UNIT_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_i,
   input  logic              fall_i,
   input  logic              rise_i,
   input  logic [UNIT_W-1:0] unit_i,
   output owm_ev_e           ev_o,
   output logic              ev_bit_o
);

   logic             active_q;
   logic             low_q;
   logic             pend_q;
   logic             bit_q;
   logic [CNT_W-1:0] ecnt_q;

   logic [CNT_W-1:0] thr1;
   logic [CNT_W-1:0] thr2;
   logic [CNT_W-1:0] thr8;
   logic             at_sample;
   logic [CNT_W-1:0] ecnt_nxt;

   assign thr1 = CNT_W'(unit_i);
   assign thr2 = CNT_W'(unit_i) * CNT_W'(OWM_DATA_MULT);
   assign thr8 = CNT_W'(unit_i) * CNT_W'(OWM_RST_MULT);

   assign at_sample = active_q && (ecnt_q == thr1);
   assign ecnt_nxt  = (&ecnt_q) ? ecnt_q : ecnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         low_q    <= 1'b0;
         pend_q   <= 1'b0;
         bit_q    <= 1'b0;
         ecnt_q   <= '0;
         ev_o     <= EV_NONE;
         ev_bit_o <= 1'b0;
      end else begin
         ev_o <= EV_NONE;
         if (fall_i) begin
            active_q <= 1'b1;
            low_q    <= 1'b1;
            pend_q   <= 1'b0;
            ecnt_q   <= CNT_W'(1);
         end else if (active_q) begin
            ecnt_q <= ecnt_nxt;
            if (at_sample) bit_q <= line_i;
            if (low_q && rise_i) begin
               low_q <= 1'b0;
               if (ecnt_q >= thr8) begin
                  ev_o     <= EV_RST;
                  active_q <= 1'b0;
               end else if (ecnt_q >= thr2) begin
                  ev_o     <= EV_ERR;
                  active_q <= 1'b0;
               end else if (ecnt_q >= thr1) begin
                  ev_o     <= EV_BIT;
                  ev_bit_o <= at_sample ? line_i : bit_q;
                  active_q <= 1'b0;
               end else begin
                  pend_q <= 1'b1;
               end
            end else if (pend_q && at_sample) begin
               ev_o     <= EV_BIT;
               ev_bit_o <= line_i;
               active_q <= 1'b0;
               pend_q   <= 1'b0;
            end
         end
      end
   end

   a_r3_bit_from_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_o == EV_BIT) |-> $past(active_q));

   a_r5_rst_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_o == EV_RST) |-> $past(rise_i));

   a_r6_err_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_o == EV_ERR) |-> $past(rise_i));

   a_r2_pend_only_low_done: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> !low_q);

endmodule

// File: rtl/owm_byte_asm.sv
module owm_byte_asm #(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned CW = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_vld_i,
   input  logic              bit_i,
   input  logic              clr_i,
   output logic              byte_vld_o,
   output logic [DATA_W-1:0] byte_o
);

   logic [CW-1:0]     cnt_q;
   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] sh_nxt;

   assign sh_nxt = {bit_i, sh_q[DATA_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         sh_q       <= '0;
         byte_vld_o <= 1'b0;
         byte_o     <= '0;
      end else begin
         byte_vld_o <= 1'b0;
         if (clr_i) begin
            cnt_q <= '0;
         end else if (bit_vld_i) begin
            sh_q <= sh_nxt;
            if (cnt_q == CW'(DATA_W - 1)) begin
               cnt_q      <= '0;
               byte_vld_o <= 1'b1;
               byte_o     <= sh_nxt;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   a_r4_byte_follows_bit: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |-> $past(bit_vld_i));

   a_r5_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/owm_bit_monitor.sv
module owm_bit_monitor
   import owm_pkg::*;
#(
   parameter int unsigned UNIT_W      = 12,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned OD_SHIFT    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_i,
   input  logic [UNIT_W-1:0] unit_i,
   input  logic              od_mode_i,
   output logic              byte_vld_o,
   output logic [DATA_W-1:0] byte_o,
   output logic              bus_rst_o,
   output logic              err_o
);

   generate
      if (UNIT_W < 2)         begin : g_bad_unit  $error("UNIT_W must be at least 2");       end
      if (DATA_W < 2)         begin : g_bad_data  $error("DATA_W must be at least 2");       end
      if (SYNC_STAGES < 1)    begin : g_bad_sync  $error("SYNC_STAGES must be at least 1");  end
      if (OD_SHIFT >= UNIT_W) begin : g_bad_shift $error("OD_SHIFT must be below UNIT_W");   end
   endgenerate

   logic              line_s;
   logic              fall;
   logic              rise;
   logic [UNIT_W-1:0] unit_od;
   logic [UNIT_W-1:0] unit_sel;
   logic [UNIT_W-1:0] unit_eff;
   owm_ev_e           ev;
   logic              ev_bit;

   generate
      if (OD_SHIFT == 0) begin : g_od_same
         assign unit_od = unit_i;
      end else begin : g_od_shift
         assign unit_od = unit_i >> OD_SHIFT;
      end
   endgenerate

   assign unit_sel = od_mode_i ? unit_od : unit_i;
   assign unit_eff = (unit_sel == '0) ? UNIT_W'(1) : unit_sel;

   owm_line_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (line_i),
      .line_o (line_s),
      .fall_o (fall),
      .rise_o (rise)
   );

   owm_slot_timer #(
      .UNIT_W (UNIT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_i   (line_s),
      .fall_i   (fall),
      .rise_i   (rise),
      .unit_i   (unit_eff),
      .ev_o     (ev),
      .ev_bit_o (ev_bit)
   );

   owm_byte_asm #(
      .DATA_W (DATA_W)
   ) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_vld_i  (ev == EV_BIT),
      .bit_i      (ev_bit),
      .clr_i      ((ev == EV_RST) || (ev == EV_ERR)),
      .byte_vld_o (byte_vld_o),
      .byte_o     (byte_o)
   );

   assign bus_rst_o = (ev == EV_RST);
   assign err_o     = (ev == EV_ERR);

   a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({byte_vld_o, bus_rst_o, err_o}));

   a_r7_unit_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      unit_eff != '0);

endmodule

// File: tb/owm_bit_monitor_tb.sv
module owm_bit_monitor_tb;

   localparam int UW = 12;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          line_i = 1'b0;
   logic [UW-1:0] unit_i = UW'(10);
   logic          od_mode_i = 1'b0;
   logic          byte_vld_o;
   logic [DW-1:0] byte_o;
   logic          bus_rst_o;
   logic          err_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // kind: 0 byte, 1 reset, 2 error
   int    exp_kind[$];
   int    exp_data[$];
   string exp_tag[$];

   always #10 clk = ~clk;

   owm_bit_monitor u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_i     (line_i),
      .unit_i     (unit_i),
      .od_mode_i  (od_mode_i),
      .byte_vld_o (byte_vld_o),
      .byte_o     (byte_o),
      .bus_rst_o  (bus_rst_o),
      .err_o      (err_o)
   );

   task automatic push(int kind, int data, string tag);
      exp_kind.push_back(kind);
      exp_data.push_back(data);
      exp_tag.push_back(tag);
   endtask

   task automatic pulse(int n, int gap);
      @(negedge clk) line_i = 1'b0;
      repeat (n) @(negedge clk);
      line_i = 1'b1;
      repeat (gap) @(negedge clk);
   endtask

   task automatic send_byte(logic [7:0] b, int one_len, int zero_len, int gap, string tag);
      push(0, int'(b), tag);
      for (int i = 0; i < 8; i++) pulse(b[i] ? one_len : zero_len, gap);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int n;
         int kind;
         n = int'(byte_vld_o) + int'(bus_rst_o) + int'(err_o);
         if (n > 1) begin
            checks++; errors++;
            $display("FAIL R9: %0d strobes in one cycle, expected at most 1", n);
         end else if (n == 1) begin
            kind = byte_vld_o ? 0 : (bus_rst_o ? 1 : 2);
            checks++;
            if (exp_kind.size() == 0) begin
               errors++;
               $display("FAIL R8: unexpected event kind %0d (data %02h), expected none", kind, byte_o);
            end else begin
               int ek; int ed; string et;
               ek = exp_kind.pop_front();
               ed = exp_data.pop_front();
               et = exp_tag.pop_front();
               if (ek != kind || (kind == 0 && int'(byte_o) != ed)) begin
                  errors++;
                  $display("FAIL %s: got kind %0d data %02h, expected kind %0d data %02h",
                           et, kind, byte_o, ek, ed);
               end
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R8: line held low through reset
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      checks++;
      if (byte_vld_o || bus_rst_o || err_o || byte_o != 8'h00) begin
         errors++;
         $display("FAIL R1: outputs %b%b%b byte %02h, expected 000 byte 00",
                  byte_vld_o, bus_rst_o, err_o, byte_o);
      end
      repeat (20) @(negedge clk);
      line_i = 1'b1;              // R8: rise without a seen fall, no event
      repeat (30) @(negedge clk);

      // U = 10: one = 2 cycles, zero = 15 cycles
      send_byte(8'hA5, 2, 15, 14, "R4");
      send_byte(8'h3C, 2, 15, 14, "R4");
      send_byte(8'hFF, 2, 15, 14, "R3");
      send_byte(8'h00, 2, 15, 14, "R3");

      // R2 boundary: lengths U,2U-1,1,U+1,U,U,2U-1,1 -> 1,0,1,0,1,1,0,1 = B5
      push(0, 'hB5, "R2");
      pulse(10, 14); pulse(19, 14); pulse(1, 14); pulse(11, 14);
      pulse(10, 14); pulse(10, 14); pulse(19, 14); pulse(1, 14);

      // R5: partial bits then reset of exactly 8U, then clean byte
      pulse(2, 14); pulse(15, 14); pulse(2, 14);
      push(1, 0, "R5");
      pulse(80, 20);
      send_byte(8'h5A, 2, 15, 14, "R5");
      push(1, 0, "R5");
      pulse(120, 20);

      // R6: partial bits then pulse of exactly 2U, then clean byte
      for (int i = 0; i < 5; i++) pulse(2, 14);
      push(2, 0, "R6");
      pulse(20, 20);
      send_byte(8'h81, 2, 15, 14, "R6");
      push(2, 0, "R6");
      pulse(79, 20);

      // R7: overdrive, unit 40 >> 2 = 10
      unit_i = UW'(40);
      od_mode_i = 1'b1;
      repeat (5) @(negedge clk);
      send_byte(8'h96, 2, 15, 14, "R7");
      push(2, 0, "R7");
      pulse(30, 20);               // 3U in overdrive: error
      // standard speed with unit 40: 30-cycle pulse is a 1, 60 is a 0
      od_mode_i = 1'b0;
      repeat (5) @(negedge clk);
      send_byte(8'h0F, 30, 60, 44, "R7");

      repeat (50) @(negedge clk);
      checks++;
      if (exp_kind.size() != 0) begin
         errors++;
         $display("FAIL R9: %0d expected events never seen, expected 0", exp_kind.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule